// File: doc/BRIEF.md
# Translation Fault Status Encoder

This block sits between a soft processor's memory access paths (load, store, instruction fetch) and a translation lookup unit. For every access request it decides whether address translation applies. The decision rests on two layered configuration checks and on the virtual-mode bit of the machine status register. The block then either forms the physical page address and its protection bits, or reports a translation fault.

On a fault it writes the faulting address into the exception address register and a status code into the exception status register. It also raises an MMU exception request, which stays pending until the processor acknowledges it. A second fault that arrives while a request is still pending is a fatal condition. So is a lookup that reports an error kind the block does not recognise. Both are flagged on a sticky error output.

All results are registered. They are valid on the cycle after the request strobe.

Top module: `xfe_top`

## Requirements
- R1: Translation is available only when `cfg_mmu_present` is 1. When `cfg_full` is also 1, every bit of `cfg_ext_mmu` must be 1, or translation is treated as absent.
- R2: When translation is unavailable or `vm_mode` is 0, the response reports success. `phys_addr` is the access address with its low PAGE_BITS bits cleared, and `phys_prot` is all ones.
- R3: When translating and `lu_hit` is 1, the response reports success. `phys_addr` = `lu_pbase` + (page-aligned access address − `lu_vbase`), modulo 2^ADDR_W, and `phys_prot` = `lu_prot`.
- R4: When translating and `lu_hit` is 0, `esr_val` bits [4:0] carry the fault code. The code is taken from `lu_err` and `acc_kind`. A protection error (`lu_err`=0) gives 17 for a fetch (`acc_kind`=2) and 16 otherwise. A miss (`lu_err`=1) gives 19 for a fetch and 18 otherwise. `acc_kind` 0 is a load, 1 is a store and 3 is treated as a load. All other ESR bits except bit 10 are zero.
- R5: On a fault caused by a store (`acc_kind`=1), bit 10 of `esr_val` is 1. For any other access kind it is 0.
- R6: On a fault, `rsp_ok` is 0 and `phys_addr` and `phys_prot` are zero. `ear_we` and `esr_we` pulse for one cycle, `ear_val` holds the full access address, and `exc_req` becomes 1.
- R7: `exc_req` stays 1 until a cycle with `exc_ack` = 1 and no new fault. It is 0 on the following cycle.
- R8: A fault that arrives while `exc_req` is already 1 still updates the registers, and it sets `fatal_err`. `fatal_err` stays 1 until reset.
- R9: A translated miss with `lu_err` of 2 or 3 sets `fatal_err`. It writes neither register and raises no exception request.
- R10: After reset all outputs are zero. Each `req_valid` cycle yields exactly one `rsp_valid` pulse on the next cycle, and `ear_val`/`esr_val` hold their values between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| acc_addr | input | ADDR_W | Access (virtual) address |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| cfg_mmu_present | input | 1 | Base configuration: MMU present |
| cfg_full | input | 1 | Full configuration flag |
| cfg_ext_mmu | input | EXT_W | Extended configuration MMU field |
| vm_mode | input | 1 | Virtual-mode bit of the machine status register |
| lu_hit | input | 1 | Lookup hit |
| lu_err | input | 2 | Lookup error kind: 0 protection, 1 miss |
| lu_vbase | input | ADDR_W | Matching entry virtual base |
| lu_pbase | input | ADDR_W | Matching entry physical base |
| lu_prot | input | PROT_W | Matching entry protection bits |
| exc_ack | input | 1 | Processor takes the pending MMU exception |
| rsp_valid | output | 1 | Response valid |
| rsp_ok | output | 1 | Access mapped without fault |
| phys_addr | output | ADDR_W | Physical page address |
| phys_prot | output | PROT_W | Granted protection bits |
| ear_we | output | 1 | Exception address register write pulse |
| ear_val | output | ADDR_W | Exception address register value |
| esr_we | output | 1 | Exception status register write pulse |
| esr_val | output | 32 | Exception status register value |
| exc_req | output | 1 | MMU exception request pending |
| fatal_err | output | 1 | Sticky recursive-fault / illegal-error flag |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 4 KiB page (PAGE_BITS = 12), 3 protection bits and a 2-bit extended MMU field. With a 2-bit field, the partly-set field values that must disable translation are few enough to hit both directly and at random. Random entry bases exercise the modulo wrap of the base-difference arithmetic. The 12-bit offset shows that bypass clears exactly the in-page bits while keeping the page number.

// File: rtl/xfe_pkg.sv
// Shared encodings for the translation fault status encoder.
package xfe_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        LKE_PROT = 2'd0,
        LKE_MISS = 2'd1,
        LKE_BAD2 = 2'd2,
        LKE_BAD3 = 2'd3
    } lk_err_e;

    localparam int          STORE_FLAG_BIT = 10;
    localparam int          CODE_W         = 5;
    localparam logic [4:0]  CODE_PROT_DATA = 5'd16;
    localparam logic [4:0]  CODE_PROT_INSN = 5'd17;
    localparam logic [4:0]  CODE_MISS_DATA = 5'd18;
    localparam logic [4:0]  CODE_MISS_INSN = 5'd19;

    typedef struct packed {
        logic       illegal;
        logic [4:0] code;
        logic       store;
    } fault_info_t;
endpackage

// File: rtl/xfe_gate.sv
// Decides whether an access is translated.
// Assumes: the extended field counts as complete only when all of its bits are set.
module xfe_gate #(
    parameter int EXT_W = 2
) (
    input  logic             cfg_mmu_present,
    input  logic             cfg_full,
    input  logic [EXT_W-1:0] cfg_ext_mmu,
    input  logic             vm_mode,
    output logic             available,
    output logic             translate
);
    // Layered availability check, then the virtual-mode gate.
    always_comb begin
        available = cfg_mmu_present && (!cfg_full || (&cfg_ext_mmu));
        translate = available && vm_mode;
    end
endmodule

// File: rtl/xfe_addr_calc.sv
// Forms the physical page address for a mapped or bypassed access.
// Assumes: the entry bases are page-aligned; arithmetic wraps at ADDR_W bits.
module xfe_addr_calc #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] vbase,
    input  logic [ADDR_W-1:0] pbase,
    input  logic              translate,
    output logic [ADDR_W-1:0] phys
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0] page_addr;

    // Page-align the access address and relocate it when translating.
    always_comb begin
        page_addr = acc_addr & PAGE_MASK;
        phys      = translate ? (pbase + (page_addr - vbase)) : page_addr;
    end
endmodule

// File: rtl/xfe_status_enc.sv
// Encodes the fault status code from error kind and access kind.
// Assumes: only protection and miss error kinds are legal.
module xfe_status_enc (
    input  logic [1:0]          acc_kind,
    input  logic [1:0]          lu_err,
    output xfe_pkg::fault_info_t info
);
    import xfe_pkg::*;

    logic is_fetch;

    // Choose the code from the joint error/access kind.
    always_comb begin
        is_fetch     = (acc_kind == ACC_FETCH);
        info.store   = (acc_kind == ACC_STORE);
        info.illegal = 1'b0;
        unique case (lu_err)
            LKE_PROT: info.code = is_fetch ? CODE_PROT_INSN : CODE_PROT_DATA;
            LKE_MISS: info.code = is_fetch ? CODE_MISS_INSN : CODE_MISS_DATA;
            default: begin
                info.code    = '0;
                info.illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xfe_top.sv
// Translation fault status encoder: registers the mapping result or the
// fault report one cycle after each request and tracks the pending MMU
// exception and fatal conditions.
// Assumes: one request per cycle at most; exc_ack comes from the core.
module xfe_top #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int PROT_W    = 3,
    parameter int EXT_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              cfg_mmu_present,
    input  logic              cfg_full,
    input  logic [EXT_W-1:0]  cfg_ext_mmu,
    input  logic              vm_mode,
    input  logic              lu_hit,
    input  logic [1:0]        lu_err,
    input  logic [ADDR_W-1:0] lu_vbase,
    input  logic [ADDR_W-1:0] lu_pbase,
    input  logic [PROT_W-1:0] lu_prot,
    input  logic              exc_ack,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [PROT_W-1:0] phys_prot,
    output logic              ear_we,
    output logic [ADDR_W-1:0] ear_val,
    output logic              esr_we,
    output logic [31:0]       esr_val,
    output logic              exc_req,
    output logic              fatal_err
);
    import xfe_pkg::*;

    logic              available;
    logic              translate;
    logic [ADDR_W-1:0] phys_next;
    fault_info_t       finfo;
    logic              missed;
    logic              fault_now;
    logic              illegal_now;
    logic [31:0]       esr_next;

    xfe_gate #(.EXT_W(EXT_W)) u_gate (
        .cfg_mmu_present (cfg_mmu_present),
        .cfg_full        (cfg_full),
        .cfg_ext_mmu     (cfg_ext_mmu),
        .vm_mode         (vm_mode),
        .available       (available),
        .translate       (translate)
    );

    xfe_addr_calc #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_addr (
        .acc_addr  (acc_addr),
        .vbase     (lu_vbase),
        .pbase     (lu_pbase),
        .translate (translate),
        .phys      (phys_next)
    );

    xfe_status_enc u_enc (
        .acc_kind (acc_kind),
        .lu_err   (lu_err),
        .info     (finfo)
    );

    // Classify the current request and assemble the status word.
    always_comb begin
        missed      = req_valid && translate && !lu_hit;
        fault_now   = missed && !finfo.illegal;
        illegal_now = missed && finfo.illegal;
        esr_next    = '0;
        esr_next[CODE_W-1:0]    = finfo.code;
        esr_next[STORE_FLAG_BIT] = finfo.store;
    end

    // Response registers: mapping result or cleared on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            phys_addr <= '0;
            phys_prot <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                if (!translate || lu_hit) begin
                    rsp_ok    <= 1'b1;
                    phys_addr <= phys_next;
                    phys_prot <= translate ? lu_prot : '1;
                end else begin
                    rsp_ok    <= 1'b0;
                    phys_addr <= '0;
                    phys_prot <= '0;
                end
            end
        end
    end

    // Exception address and status register updates on a legal fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ear_we  <= 1'b0;
            esr_we  <= 1'b0;
            ear_val <= '0;
            esr_val <= '0;
        end else begin
            ear_we <= fault_now;
            esr_we <= fault_now;
            if (fault_now) begin
                ear_val <= acc_addr;
                esr_val <= esr_next;
            end
        end
    end

    // Pending exception request: set by a fault, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_req <= 1'b0;
        end else if (fault_now) begin
            exc_req <= 1'b1;
        end else if (exc_ack) begin
            exc_req <= 1'b0;
        end
    end

    // Sticky fatal flag for recursive faults and illegal error kinds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fatal_err <= 1'b0;
        end else if ((fault_now && exc_req) || illegal_now) begin
            fatal_err <= 1'b1;
        end
    end

    AST_BYPASS_FULLPROT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(vm_mode)) |-> (rsp_ok && (&phys_prot) && (phys_addr[PAGE_BITS-1:0] == '0))); // R2
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        esr_we |-> (esr_val[4:0] >= 5'd16 && esr_val[4:0] <= 5'd19)); // R4
    AST_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        esr_we |-> (esr_val[STORE_FLAG_BIT] == ($past(acc_kind) == ACC_STORE))); // R5
    AST_FAULT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        esr_we |-> (exc_req && !rsp_ok)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ack && !fault_now) |=> !exc_req); // R7
    AST_RECURSE_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_now && exc_req) |=> fatal_err); // R8
    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> fatal_err); // R8
    AST_ILLEGAL_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_now |=> (!esr_we && !ear_we && fatal_err)); // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
endmodule

// File: tb/xfe_top_bench.sv
module xfe_top_bench;
    localparam int AW = 32;
    localparam int PB = 12;
    localparam int PW = 3;
    localparam int EW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_kind = '0;
    logic          cfg_mmu_present = 1'b0;
    logic          cfg_full = 1'b0;
    logic [EW-1:0] cfg_ext_mmu = '0;
    logic          vm_mode = 1'b0;
    logic          lu_hit = 1'b0;
    logic [1:0]    lu_err = '0;
    logic [AW-1:0] lu_vbase = '0;
    logic [AW-1:0] lu_pbase = '0;
    logic [PW-1:0] lu_prot = '0;
    logic          exc_ack = 1'b0;
    logic          rsp_valid, rsp_ok, ear_we, esr_we, exc_req, fatal_err;
    logic [AW-1:0] phys_addr, ear_val;
    logic [PW-1:0] phys_prot;
    logic [31:0]   esr_val;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    // Bench model state
    bit            m_pend = 0;
    bit            m_fatal = 0;
    logic [AW-1:0] m_ear = '0;
    logic [31:0]   m_esr = '0;

    always #5 clk = ~clk;

    xfe_top #(.ADDR_W(AW), .PAGE_BITS(PB), .PROT_W(PW), .EXT_W(EW)) u_xfe_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .cfg_mmu_present(cfg_mmu_present), .cfg_full(cfg_full),
        .cfg_ext_mmu(cfg_ext_mmu), .vm_mode(vm_mode), .lu_hit(lu_hit), .lu_err(lu_err),
        .lu_vbase(lu_vbase), .lu_pbase(lu_pbase), .lu_prot(lu_prot), .exc_ack(exc_ack),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .phys_addr(phys_addr), .phys_prot(phys_prot),
        .ear_we(ear_we), .ear_val(ear_val), .esr_we(esr_we), .esr_val(esr_val),
        .exc_req(exc_req), .fatal_err(fatal_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit f_xlat(bit pres, bit full, logic [EW-1:0] ext, bit vm);
        return pres && (!full || ext == '1) && vm;
    endfunction

    function automatic logic [31:0] f_esr(logic [1:0] kind, logic [1:0] err);
        logic [31:0] v = '0;
        v[4:0] = (err == 2'd0) ? ((kind == 2'd2) ? 5'd17 : 5'd16)
                               : ((kind == 2'd2) ? 5'd19 : 5'd18);
        v[10]  = (kind == 2'd1);
        return v;
    endfunction

    // One request: drive at negedge, check at the following negedge.
    task automatic do_req(input logic [AW-1:0] a, input logic [1:0] k, input bit pres,
                          input bit full, input logic [EW-1:0] ext, input bit vm,
                          input bit hit, input logic [1:0] err, input logic [AW-1:0] vb,
                          input logic [AW-1:0] pb, input logic [PW-1:0] pr);
        bit            xl, flt, ill;
        logic [AW-1:0] pg, e_phys;
        logic [PW-1:0] e_prot;
        @(negedge clk);
        req_valid = 1'b1; acc_addr = a; acc_kind = k; cfg_mmu_present = pres;
        cfg_full = full; cfg_ext_mmu = ext; vm_mode = vm; lu_hit = hit; lu_err = err;
        lu_vbase = vb; lu_pbase = pb; lu_prot = pr;
        xl  = f_xlat(pres, full, ext, vm);
        pg  = a & ~((AW'(1) << PB) - 1);
        flt = xl && !hit && err < 2;
        ill = xl && !hit && err >= 2;
        e_phys = !xl ? pg : (hit ? pb + (pg - vb) : '0);
        e_prot = !xl ? '1 : (hit ? pr : '0);
        if ((flt && m_pend) || ill) m_fatal = 1;
        if (flt) begin m_pend = 1; m_ear = a; m_esr = f_esr(k, err); end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd1);
        chk(xl ? "R3/R1 rsp_ok" : "R2/R1 rsp_ok", 32'(rsp_ok), 32'(!(flt || ill)));
        chk(xl ? "R3 phys_addr" : "R2 phys_addr", phys_addr, e_phys);
        chk(xl ? "R3 phys_prot" : "R2 phys_prot", 32'(phys_prot), 32'(e_prot));
        chk(ill ? "R9 esr_we" : "R6 esr_we", 32'(esr_we), 32'(flt));
        chk("R6 ear_we", 32'(ear_we), 32'(flt));
        chk("R6 ear_val", ear_val, m_ear);
        chk("R4/R5 esr_val", esr_val, m_esr);
        chk("R7 exc_req", 32'(exc_req), 32'(m_pend));
        chk("R8 fatal_err", 32'(fatal_err), 32'(m_fatal));
        @(negedge clk);
        chk("R10 rsp_valid pulse", 32'(rsp_valid), 32'd0);
    endtask

    task automatic do_ack();
        @(negedge clk);
        exc_ack = 1'b1;
        @(negedge clk);
        exc_ack = 1'b0;
        m_pend = 0;
        chk("R7 ack clears exc_req", 32'(exc_req), 32'd0);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset rsp_valid", 32'(rsp_valid), 0);
        chk("R10 reset phys_addr", phys_addr, 0);
        chk("R10 reset exc_req", 32'(exc_req), 0);
        chk("R10 reset fatal_err", 32'(fatal_err), 0);
        chk("R10 reset esr_val", esr_val, 0);
        // R1: layered availability, all combinations with vm on and a miss lookup
        do_req(32'h1234_5678, 2'd0, 0, 0, 2'b11, 1, 0, 2'd1, 0, 0, 0);
        do_req(32'h1234_5678, 2'd0, 1, 1, 2'b01, 1, 0, 2'd1, 0, 0, 0);
        do_req(32'h1234_5678, 2'd0, 1, 1, 2'b10, 1, 0, 2'd1, 0, 0, 0);
        // R2: vm off bypass
        do_req(32'hFFFF_FFFF, 2'd2, 1, 0, 2'b00, 0, 0, 2'd0, 0, 0, 0);
        // R3: hit with wrap
        do_req(32'h0000_3ABC, 2'd1, 1, 1, 2'b11, 1, 1, 2'd0, 32'h0000_5000, 32'h0000_1000, 3'b101);
        // R4/R5/R6: each code, store flag, then ack (R7)
        do_req(32'hDEAD_BEEF, 2'd2, 1, 0, 2'b00, 1, 0, 2'd0, 0, 0, 0); do_ack();
        do_req(32'hCAFE_0001, 2'd1, 1, 0, 2'b00, 1, 0, 2'd0, 0, 0, 0); do_ack();
        do_req(32'h0BAD_F00D, 2'd2, 1, 1, 2'b11, 1, 0, 2'd1, 0, 0, 0); do_ack();
        do_req(32'h7777_0123, 2'd1, 1, 0, 2'b00, 1, 0, 2'd1, 0, 0, 0); do_ack();
        do_req(32'h0000_0FFF, 2'd3, 1, 0, 2'b00, 1, 0, 2'd1, 0, 0, 0); do_ack();
        // Random phase
        for (int i = 0; i < 600; i++) begin
            do_req($urandom, 2'($urandom), 1'($urandom), 1'($urandom), EW'($urandom),
                   ($urandom % 4) != 0, 1'($urandom), 2'($urandom % 2),
                   $urandom & 32'hFFFF_F000, $urandom & 32'hFFFF_F000, PW'($urandom));
            if (m_pend) do_ack();
        end
        // R8: recursive fault, then R9: illegal error kind
        do_req(32'h1111_1000, 2'd0, 1, 0, 2'b00, 1, 0, 2'd1, 0, 0, 0);
        do_req(32'h2222_2004, 2'd1, 1, 0, 2'b00, 1, 0, 2'd0, 0, 0, 0);
        do_ack();
        rst_n = 1'b0; m_fatal = 0; m_pend = 0; m_ear = '0; m_esr = '0;
        @(negedge clk); rst_n = 1'b1;
        do_req(32'h3333_3000, 2'd0, 1, 0, 2'b00, 1, 0, 2'd2, 0, 0, 0);
        do_req(32'h4444_4000, 2'd2, 1, 0, 2'b00, 1, 0, 2'd3, 0, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule